// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps the time of day and the calendar date in packed BCD. It holds eight time fields: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. A prescaled 100 Hz strobe (`tick_i`) advances the fields, and carries ripple from hundredths up to the year within one strobe. The date wraps on the real last day of each month, and February gets leap-year correction. The hour field runs in 24-hour format or in 12-hour format with an AM/PM flag.

A host accesses the fields through a small asynchronous-style bus that is sampled on the core clock. The bus has a 6-bit address, 8-bit write and read data, and active-low chip, write and output enables. Reads return a snapshot of all fields that is captured when chip enable falls, so a multi-byte read stays coherent while the clock keeps running. A power-fail input locks out every bus write but does not stop timekeeping. The read side drives the data bus through an output-enable flag (`data_oe_o`). When that flag is low the bus is to be left undriven.

Top module: `rtc_core`

## Requirements
- R1: After reset the fields read hundredths 00 (address 0), seconds 00 (1), minutes 00 (2), hours 00 in 24-hour mode (3), day of week 01 (4), date 01 (5), month 01 (6) and year 00 (7).
- R2: Each cycle with `tick_i` high adds one to the BCD hundredths. The wraps 99→00 (hundredths), 59→00 (seconds) and 59→00 (minutes) each carry into the next field in the same cycle.
- R3: In 24-hour mode (hours bit 7 = 0, hours in bits 5:0) the hours wrap 23→00 and carry into the date. Each date increment also advances the day of week, which cycles 1 to 7 and then back to 1.
- R4: In 12-hour mode (hours bit 7 = 1, PM flag in bit 5, hours 01–12 in bits 4:0) the hour goes 11→12 and toggles PM, and goes 12→01 without toggling. Only the step from 11 PM to 12 AM carries into the date.
- R5: April, June, September and November end after day 30, and all other months except February end after day 31. At that point the date goes to 01 and the month advances.
- R6: February ends after day 29 when the year is divisible by 4, and after day 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: `data_oe_o` is high only while chip enable has been low for at least one earlier clock, write enable is high and output enable is low. While `data_oe_o` is low, `data_o` is 00.
- R8: Read data comes from a copy of all fields taken at the first clock edge with chip enable low. Ticks that occur during that chip-enable-low session do not change the data read.
- R9: A write (chip and write enable both low) lands in the addressed field at that clock edge. A write to seconds also clears the hundredths to 00.
- R10: While `pwr_fail_i` is high, writes have no effect, but ticks still advance time.
- R11: A field that holds invalid BCD or an out-of-range value is set to its minimum on the next tick (a 12-hour hour becomes 01 with its PM flag kept), and it generates no carry.
- R12: Addresses 8 to 63 read as 00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 100 Hz advance strobe, one clock wide |
| pwr_fail_i | input | 1 | Supply fault, locks out writes |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 6 | Register address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data (00 when not driven) |
| data_oe_o | output | 1 | Read data bus drive enable |

## Verification
Writes and ticks take effect at the clock edge where they are sampled. A write is therefore visible to any read session that starts afterwards, and a tick's full carry ripple shows up in every field together. Read data becomes valid one edge after chip enable falls, because the snapshot and the drive qualifier are both registered there.

The bench raises each input just after a rising edge. It compares read data at the following falling edge, once the snapshot edge has passed. Its scoreboard queues the expected byte before each read session, and the monitor pops that byte at exactly that falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD  = 8;
  localparam int F_HUND  = 0;
  localparam int F_SEC   = 1;
  localparam int F_MIN   = 2;
  localparam int F_HOUR  = 3;
  localparam int F_DOW   = 4;
  localparam int F_DATE  = 5;
  localparam int F_MONTH = 6;
  localparam int F_YEAR  = 7;

  function automatic logic [7:0] field_min(int i);
    case (i)
      F_DOW, F_DATE, F_MONTH: return 8'h01;
      default:                return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_max(int i);
    case (i)
      F_HUND, F_YEAR: return 8'h99;
      F_SEC, F_MIN:   return 8'h59;
      F_HOUR:         return 8'h23;
      F_DOW:          return 8'h07;
      F_MONTH:        return 8'h12;
      default:        return 8'h31;
    endcase
  endfunction

  // date is fed by the hour carry, skipping day of week
  function automatic int carry_src(int i);
    return (i == F_DATE) ? F_HOUR : i - 1;
  endfunction

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic bcd_ok(logic [7:0] v);
    return (v[3:0] <= 4'h9) && (v[7:4] <= 4'h9);
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
  import rtc_pkg::*;
(
  input  logic       en_i,
  input  logic       inc_i,
  input  logic [7:0] val_i,
  input  logic [7:0] min_i,
  input  logic [7:0] max_i,
  output logic [7:0] nxt_o,
  output logic       cy_o
);
  logic valid;
  assign valid = bcd_ok(val_i) && (val_i >= min_i) && (val_i <= max_i);

  always_comb begin
    nxt_o = val_i;
    cy_o  = 1'b0;
    if (en_i) begin
      if (!valid) begin
        nxt_o = min_i;
      end else if (inc_i) begin
        if (val_i == max_i) begin
          nxt_o = min_i;
          cy_o  = 1'b1;
        end else begin
          nxt_o = bcd_inc(val_i);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
  import rtc_pkg::*;
(
  input  logic       en_i,
  input  logic       inc_i,
  input  logic [7:0] val_i,
  output logic [7:0] nxt_o,
  output logic       cy_o
);
  logic       mode12, pm;
  logic [4:0] h12;
  logic [5:0] h24;
  logic       ok12, ok24;
  logic [7:0] inc12, inc24;

  assign mode12 = val_i[7];
  assign pm     = val_i[5];
  assign h12    = val_i[4:0];
  assign h24    = val_i[5:0];
  assign ok12   = bcd_ok({3'b000, h12}) && (h12 != 5'h00) && (h12 <= 5'h12);
  assign ok24   = !val_i[6] && bcd_ok({2'b00, h24}) && (h24 <= 6'h23);
  assign inc12  = bcd_inc({3'b000, h12});
  assign inc24  = bcd_inc({2'b00, h24});

  always_comb begin
    nxt_o = val_i;
    cy_o  = 1'b0;
    if (en_i) begin
      if (mode12) begin
        if (!ok12) begin
          nxt_o = {1'b1, 1'b0, pm, 5'h01};
        end else if (inc_i) begin
          if (h12 == 5'h12) begin
            nxt_o = {1'b1, 1'b0, pm, 5'h01};
          end else if (h12 == 5'h11) begin
            nxt_o = {1'b1, 1'b0, ~pm, 5'h12};
            cy_o  = pm;
          end else begin
            nxt_o = {1'b1, 1'b0, pm, inc12[4:0]};
          end
        end
      end else begin
        if (!ok24) begin
          nxt_o = 8'h00;
        end else if (inc_i) begin
          if (h24 == 6'h23) begin
            nxt_o = 8'h00;
            cy_o  = 1'b1;
          end else begin
            nxt_o = {2'b00, inc24[5:0]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] month_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_o
);
  logic [1:0] ymod4;
  logic       leap;

  // (10*t + u) mod 4 == (2*t + u) mod 4
  assign ymod4 = {year_i[4], 1'b0} + year_i[1:0];
  assign leap  = (ymod4 == 2'd0);

  always_comb begin
    case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwr_fail_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  localparam int                FIELD_AW = $clog2(NFIELD);
  localparam logic [ADDR_W-1:0] NF_A     = ADDR_W'(NFIELD);

  logic [7:0]        t_q      [NFIELD];
  logic [7:0]        snap_q   [NFIELD];
  logic [7:0]        nxt_tick [NFIELD];
  logic [NFIELD-1:0] inc, cy;
  logic [7:0]        last_day;
  logic              ce_q;
  logic              in_map, wr_en;
  logic [FIELD_AW-1:0] idx;
  logic [8*NFIELD-1:0] time_flat;
  logic [7:0]        hund;
  logic              unused_cy;

  assign in_map = (addr_i < NF_A);
  assign idx    = addr_i[FIELD_AW-1:0];
  assign wr_en  = !ce_ni && !we_ni && !pwr_fail_i && in_map;
  assign unused_cy = cy[F_YEAR] ^ cy[F_DOW];
  assign hund   = t_q[F_HUND];

  rtc_month_len u_mlen (
    .month_i (t_q[F_MONTH]),
    .year_i  (t_q[F_YEAR]),
    .last_o  (last_day)
  );

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    if (i == 0) begin : g_src
      assign inc[i] = tick_i;
    end else begin : g_src
      localparam int SRC = carry_src(i);
      assign inc[i] = cy[SRC];
    end

    if (i == F_HOUR) begin : g_step
      rtc_hour_step u_step (
        .en_i  (tick_i),
        .inc_i (inc[i]),
        .val_i (t_q[i]),
        .nxt_o (nxt_tick[i]),
        .cy_o  (cy[i])
      );
    end else begin : g_step
      rtc_bcd_step u_step (
        .en_i  (tick_i),
        .inc_i (inc[i]),
        .val_i (t_q[i]),
        .min_i (field_min(i)),
        .max_i ((i == F_DATE) ? last_day : field_max(i)),
        .nxt_o (nxt_tick[i]),
        .cy_o  (cy[i])
      );
    end

    assign time_flat[8*i +: 8] = t_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFIELD; i++) t_q[i] <= field_min(i);
    end else begin
      for (int i = 0; i < NFIELD; i++) t_q[i] <= nxt_tick[i];
      if (wr_en) begin
        t_q[idx] <= data_i;
        if (idx == FIELD_AW'(F_SEC)) t_q[F_HUND] <= 8'h00;
      end
    end
  end

  // coherent read copy taken on chip-enable fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b1;
      for (int i = 0; i < NFIELD; i++) snap_q[i] <= 8'h00;
    end else begin
      ce_q <= ce_ni;
      if (!ce_ni && ce_q) begin
        for (int i = 0; i < NFIELD; i++) snap_q[i] <= t_q[i];
      end
    end
  end

  assign data_oe_o = !ce_ni && !ce_q && we_ni && !oe_ni;
  assign data_o    = (data_oe_o && in_map) ? snap_q[idx] : 8'h00;
endmodule

// File: rtl/rtc_core_sva.sv
module rtc_core_sva #(
  parameter int ADDR_W = 6,
  parameter int TW     = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              pwr_fail_i,
  input logic              ce_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_o,
  input logic              data_oe_o,
  input logic [TW-1:0]     time_flat,
  input logic [7:0]        hund
);
  a_r7_drive_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && we_ni && !oe_ni));

  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 8'h00));

  a_r8_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o) && $stable(addr_i)) |-> $stable(data_o));

  a_r10_write_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && !ce_ni && !we_ni && !tick_i) |=> $stable(time_flat));

  a_r2_tick_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (ce_ni || we_ni)) |=> !$stable(hund));

  a_r9_sec_clears_hund: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni && !pwr_fail_i && addr_i == ADDR_W'(1)) |=> (hund == 8'h00));
endmodule

bind rtc_core rtc_core_sva #(.ADDR_W(ADDR_W), .TW(8*rtc_pkg::NFIELD)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .pwr_fail_i (pwr_fail_i),
  .ce_ni      (ce_ni),
  .we_ni      (we_ni),
  .oe_ni      (oe_ni),
  .addr_i     (addr_i),
  .data_o     (data_o),
  .data_oe_o  (data_oe_o),
  .time_flat  (time_flat),
  .hund       (hund)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       ce_n = 1'b1;
  logic       we_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] data_o;
  logic       data_oe_o;

  typedef struct {
    logic [7:0] data;
    logic       oe;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  logic strobe = 1'b0;
  logic done = 1'b0;
  int   n_checks = 0;
  int   n_errors = 0;

  rtc_core dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .pwr_fail_i (pwr_fail),
    .ce_ni      (ce_n),
    .we_ni      (we_n),
    .oe_ni      (oe_n),
    .addr_i     (addr),
    .data_i     (din),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops one expected item per strobe
  always @(negedge clk) begin
    if (strobe) begin
      exp_t e;
      n_checks++;
      if (sb_q.size() == 0) begin
        n_errors++;
        $display("FAIL scoreboard: no expected item queued");
      end else begin
        e = sb_q.pop_front();
        if (data_oe_o !== e.oe || data_o !== e.data) begin
          n_errors++;
          $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                   e.tag, data_oe_o, data_o, e.oe, e.data);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input logic [7:0] d, input logic oe, input string tag);
    exp_t e;
    e.data = d;
    e.oe   = oe;
    e.tag  = tag;
    sb_q.push_back(e);
    strobe = 1'b1;
    @(negedge clk);
    #1;
    strobe = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    step();
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    step();
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] d, input string tag);
    step();
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    step();
    expect_now(d, 1'b1, tag);
    step();
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse(input int n);
    repeat (n) begin
      step();
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
  endtask

  task automatic max_msh();
    wr(6'd1, 8'h59);
    wr(6'd2, 8'h59);
    wr(6'd0, 8'h99);
  endtask

  task automatic set_eod();
    wr(6'd3, 8'h23);
    max_msh();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(6'd0, 8'h00, "R1 hundredths");
    rd(6'd1, 8'h00, "R1 seconds");
    rd(6'd2, 8'h00, "R1 minutes");
    rd(6'd3, 8'h00, "R1 hours");
    rd(6'd4, 8'h01, "R1 day of week");
    rd(6'd5, 8'h01, "R1 date");
    rd(6'd6, 8'h01, "R1 month");
    rd(6'd7, 8'h00, "R1 year");

    // R7 drive qualification
    step();
    expect_now(8'h00, 1'b0, "R7 idle bus");
    step();
    ce_n = 1'b0; oe_n = 1'b1; addr = 6'd5;
    step();
    expect_now(8'h00, 1'b0, "R7 output enable high");
    step();
    ce_n = 1'b1;

    // R9 write timing and hundredths clear
    wr(6'd0, 8'h42);
    rd(6'd0, 8'h42, "R9 write lands");
    wr(6'd1, 8'h10);
    rd(6'd0, 8'h00, "R9 seconds write clears hundredths");
    rd(6'd1, 8'h10, "R9 seconds value");

    // R2 ripple through seconds and minutes
    pulse(3);
    rd(6'd0, 8'h03, "R2 three ticks");
    wr(6'd3, 8'h00);
    max_msh();
    pulse(1);
    rd(6'd0, 8'h00, "R2 hundredths wrap");
    rd(6'd1, 8'h00, "R2 seconds wrap");
    rd(6'd2, 8'h00, "R2 minutes wrap");
    rd(6'd3, 8'h01, "R2 hour carry");

    // R3 24-hour wrap, day of week 7->1
    wr(6'd5, 8'h05);
    wr(6'd6, 8'h01);
    wr(6'd4, 8'h07);
    set_eod();
    pulse(1);
    rd(6'd3, 8'h00, "R3 hours 23->00");
    rd(6'd5, 8'h06, "R3 date carry");
    rd(6'd4, 8'h01, "R3 day of week wrap");

    // R4 12-hour mode
    wr(6'd3, 8'h91);
    max_msh();
    pulse(1);
    rd(6'd3, 8'hB2, "R4 11AM->12PM");
    max_msh();
    pulse(1);
    rd(6'd3, 8'hA1, "R4 12PM->01PM");
    wr(6'd5, 8'h10);
    wr(6'd3, 8'hB1);
    max_msh();
    pulse(1);
    rd(6'd3, 8'h92, "R4 11PM->12AM");
    rd(6'd5, 8'h11, "R4 date carry at midnight");

    // R5 month lengths
    wr(6'd6, 8'h04);
    wr(6'd5, 8'h30);
    set_eod();
    pulse(1);
    rd(6'd5, 8'h01, "R5 April 30 wraps");
    rd(6'd6, 8'h05, "R5 month advance");
    wr(6'd6, 8'h03);
    wr(6'd5, 8'h30);
    set_eod();
    pulse(1);
    rd(6'd5, 8'h31, "R5 March has 31");
    rd(6'd6, 8'h03, "R5 month held");

    // R6 leap years and year wrap
    wr(6'd7, 8'h24);
    wr(6'd6, 8'h02);
    wr(6'd5, 8'h28);
    set_eod();
    pulse(1);
    rd(6'd5, 8'h29, "R6 leap February 29");
    wr(6'd7, 8'h23);
    wr(6'd5, 8'h28);
    set_eod();
    pulse(1);
    rd(6'd5, 8'h01, "R6 common February wraps");
    rd(6'd6, 8'h03, "R6 March follows");
    wr(6'd7, 8'h99);
    wr(6'd6, 8'h12);
    wr(6'd5, 8'h31);
    set_eod();
    pulse(1);
    rd(6'd7, 8'h00, "R6 year 99->00");
    rd(6'd6, 8'h01, "R6 December->January");
    rd(6'd5, 8'h01, "R6 new year date");

    // R8 snapshot coherence
    wr(6'd1, 8'h20);
    wr(6'd0, 8'h98);
    step();
    ce_n = 1'b0; oe_n = 1'b0; addr = 6'd0;
    step();
    expect_now(8'h98, 1'b1, "R8 snapshot hundredths");
    pulse(2);
    expect_now(8'h98, 1'b1, "R8 held across ticks");
    addr = 6'd1;
    step();
    expect_now(8'h20, 1'b1, "R8 snapshot seconds");
    step();
    ce_n = 1'b1; oe_n = 1'b1;
    rd(6'd0, 8'h00, "R8 live hundredths");
    rd(6'd1, 8'h21, "R8 live seconds");

    // R10 power-fail write lock
    wr(6'd1, 8'h10);
    pwr_fail = 1'b1;
    wr(6'd1, 8'h45);
    pulse(1);
    pwr_fail = 1'b0;
    rd(6'd1, 8'h10, "R10 write blocked");
    rd(6'd0, 8'h01, "R10 ticks continue");

    // R11 out-of-range clamp
    wr(6'd3, 8'h05);
    wr(6'd1, 8'h00);
    wr(6'd2, 8'h75);
    wr(6'd4, 8'h00);
    wr(6'd0, 8'h00);
    pulse(1);
    rd(6'd0, 8'h01, "R11 hundredths count");
    rd(6'd2, 8'h00, "R11 minutes clamped");
    rd(6'd3, 8'h05, "R11 no carry from clamp");
    rd(6'd4, 8'h01, "R11 day of week clamped");
    wr(6'd3, 8'h80);
    pulse(1);
    rd(6'd3, 8'h81, "R11 12-hour zero clamped");

    // R12 unmapped addresses
    wr(6'h20, 8'h5A);
    rd(6'h20, 8'h00, "R12 unmapped reads zero");
    rd(6'h3F, 8'h00, "R12 top address");
    rd(6'd3, 8'h81, "R12 mapped field untouched");

    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule